// File: doc/BRIEF.md
# Three-Wire Serial Clock Register Slave

This block is the device side of a three-wire serial link to a small clock register file. A master raises the frame enable, clocks in a command byte on the serial clock and then either clocks in data bytes or clocks out data bytes. The slave holds eight byte registers. Register 0 carries the seconds count, with its top bit used as an oscillator-halt flag. Register 7 is the control register, and its top bit is a write-protect flag. The other registers hold the remaining time fields. Each transfer moves either one addressed register or, in burst mode, the whole bank from register 0 upward.

The three serial inputs are brought into the system clock domain through synchronizers. Edges of the serial clock and of the enable are detected after that, in the system clock domain. The data output has a separate enable, so it can drive a shared data wire. The slave turns that enable on only while it is returning read data.

The block does not keep time itself. A parallel timekeeper port reads any register and overwrites any register. This lets an external counter advance the time fields while the halt flag is clear.

Top module: `rtc3w_slave`

## Requirements
- R1: After synchronous reset, register 0 and register 7 hold 0x80 and all other registers hold 0x00. `halt` is 1 and `sdo_oe` is 0.
- R2: While `ce` is high, the first 8 bits sampled on rising `sclk` edges form the command byte, received LSB first. Bit 0 set means read and bit 0 clear means write. Bits 3:1 give the register address. Bits 5:4 equal to 11 select burst mode, and any other value of bits 5:4 selects a single transfer.
- R3: In a valid single read, the addressed byte is presented LSB first on `sdo`. Each bit changes after a falling `sclk` edge, starting with the first falling edge that follows the command's last rising edge. `sdo_oe` is high only during these 8 data bits.
- R4: In a valid single write, the 8 bits that follow the command, LSB first, are stored into the addressed register once the eighth bit has been sampled.
- R5: While bit 7 of register 7 is 1, serial writes to registers 0 to 6 leave those registers unchanged. Serial writes to register 7 always take effect.
- R6: `halt` follows bit 7 of register 0, so writing 0x00 to register 0 clears `halt`.
- R7: A burst read returns registers 0 through 7 in ascending order as 64 bits, whatever the address bits are. After those 64 bits, `sdo_oe` stays low.
- R8: A burst write fills registers 0 upward, one per received byte. It stops after register 7, so further bytes in the same frame change nothing.
- R9: A command whose bit 7 is 0 or whose bit 6 is 1 is ignored. For the rest of that frame no register is written and `sdo_oe` stays low.
- R10: Dropping `ce` ends any transfer. `sdo_oe` goes low, and a partly received command or data byte is discarded. The next command is taken after the next rising edge of `ce`.
- R11: `tk_rdata` shows the register selected by `tk_addr`. When `tk_we` is high, `tk_wdata` is written to that register regardless of write protect, unless a serial write lands in the same cycle, in which case the serial write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Frame enable from the master |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data to the master |
| sdo_oe | output | 1 | Drive enable for the shared data wire |
| halt | output | 1 | Oscillator-halt flag (register 0 bit 7) |
| tk_we | input | 1 | Timekeeper write strobe |
| tk_addr | input | 3 | Timekeeper register select |
| tk_wdata | input | 8 | Timekeeper write data |
| tk_rdata | output | 8 | Timekeeper read data |

## Verification
Corrupt state in this block shows up at the ports in one of three ways. A wrong bit counter or phase state usually moves the data window by one bit. That turns a read value into a shifted pattern and makes `sdo_oe` rise or fall one serial clock early or late, so the error is visible inside the byte where it occurs. A wrong address or burst index, or a wrong write-protect decision, appears only on the next read-back of the affected register, whether that read-back comes over the serial link or through `tk_rdata`. For this reason each write is followed by a read within a frame or two. A stuck frame state appears as `sdo_oe` staying high after `ce` falls, and this is visible within a few system clocks.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
    localparam int DW       = 8;
    localparam int AW       = 3;
    localparam int NREG     = 1 << AW;
    localparam int WP_REG   = NREG - 1;
    localparam int FLAG_BIT = DW - 1;
    localparam int BCW      = $clog2(DW + 1);

    localparam logic [DW-1:0] SEC_RST  = 8'h80;
    localparam logic [DW-1:0] CTRL_RST = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic          valid;
        logic          read;
        logic          burst;
        logic [AW-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] b);
        cmd_t c;
        c.valid = b[7] & ~b[6];
        c.read  = b[0];
        c.burst = &b[5:4];
        c.addr  = b[3:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] reset_value(input int r);
        if (r == 0)           return SEC_RST;
        else if (r == WP_REG) return CTRL_RST;
        else                  return '0;
    endfunction
endpackage

// File: rtl/rtc3w_sync.sv
module rtc3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q_d <= '0;
        else     q_d <= q;
    end
endmodule

// File: rtl/rtc3w_engine.sv
module rtc3w_engine
    import rtc3w_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_rise,
    input  logic          ce_fall,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          rd_phase
);
    eng_state_e     st;
    logic [DW-1:0]  sh, tx;
    logic [BCW-1:0] bcnt;
    logic [AW-1:0]  idx;
    logic           burst_q;
    logic [DW-1:0]  nxt_sh;
    cmd_t           cmd;

    assign nxt_sh   = {sdi_s, sh[DW-1:1]};
    assign cmd      = decode_cmd(nxt_sh);
    assign rd_addr  = (st == ST_CMD) ? (cmd.burst ? '0 : cmd.addr) : idx + 1'b1;
    assign we       = (st == ST_WDATA) && sclk_rise && (bcnt == BCW'(DW-1))
                      && !ce_fall && !ce_rise;
    assign waddr    = idx;
    assign wdata    = nxt_sh;
    assign rd_phase = (st == ST_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sh      <= '0;
            tx      <= '0;
            bcnt    <= '0;
            idx     <= '0;
            burst_q <= 1'b0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else if (ce_fall) begin
            st     <= ST_IDLE;
            sdo_oe <= 1'b0;
        end else if (ce_rise) begin
            st     <= ST_CMD;
            bcnt   <= '0;
            sdo_oe <= 1'b0;
        end else begin
            case (st)
                ST_CMD: if (sclk_rise) begin
                    sh <= nxt_sh;
                    if (bcnt == BCW'(DW-1)) begin
                        bcnt    <= '0;
                        burst_q <= cmd.burst;
                        idx     <= cmd.burst ? '0 : cmd.addr;
                        tx      <= rd_data;
                        if (!cmd.valid)    st <= ST_DONE;
                        else if (cmd.read) st <= ST_RDATA;
                        else               st <= ST_WDATA;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_WDATA: if (sclk_rise) begin
                    sh <= nxt_sh;
                    if (bcnt == BCW'(DW-1)) begin
                        bcnt <= '0;
                        idx  <= idx + 1'b1;
                        if (!burst_q || idx == AW'(NREG-1)) st <= ST_DONE;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_RDATA: if (sclk_fall) begin
                    if (bcnt == BCW'(DW)) begin
                        if (burst_q && idx != AW'(NREG-1)) begin
                            sdo  <= rd_data[0];
                            tx   <= rd_data >> 1;
                            idx  <= idx + 1'b1;
                            bcnt <= BCW'(1);
                        end else begin
                            st     <= ST_DONE;
                            sdo_oe <= 1'b0;
                        end
                    end else begin
                        sdo    <= tx[0];
                        tx     <= tx >> 1;
                        bcnt   <= bcnt + 1'b1;
                        sdo_oe <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc3w_regbank.sv
module rtc3w_regbank
    import rtc3w_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_we,
    input  logic [AW-1:0]    ser_addr,
    input  logic [DW-1:0]    ser_wdata,
    input  logic             tk_we,
    input  logic [AW-1:0]    tk_addr,
    input  logic [DW-1:0]    tk_wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    tk_rdata,
    output logic [NREG*DW-1:0] bank_flat
);
    logic [DW-1:0] regs [NREG];
    logic          prot;

    assign prot = regs[WP_REG][FLAG_BIT];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[r] <= reset_value(r);
            end else if (ser_we && ser_addr == AW'(r)) begin
                if (!prot || r == WP_REG) regs[r] <= ser_wdata;
            end else if (tk_we && !ser_we && tk_addr == AW'(r)) begin
                regs[r] <= tk_wdata;
            end
        end
        assign bank_flat[r*DW +: DW] = regs[r];
    end

    assign rd_data  = regs[rd_addr];
    assign tk_rdata = regs[tk_addr];
endmodule

// File: rtl/rtc3w_slave.sv
module rtc3w_slave
    import rtc3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        halt,
    input  logic        tk_we,
    input  logic [2:0]  tk_addr,
    input  logic [7:0]  tk_wdata,
    output logic [7:0]  tk_rdata
);
    logic [2:0]          s_q, s_d;
    logic                ce_rise, ce_fall, sclk_rise, sclk_fall;
    logic [AW-1:0]       rd_addr, ser_addr;
    logic [DW-1:0]       rd_data, ser_wdata;
    logic                ser_we, rd_phase, wp;
    logic [NREG*DW-1:0]  bank_flat;

    rtc3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({sdi, sclk, ce}), .q(s_q), .q_d(s_d)
    );

    assign ce_rise   =  s_q[0] & ~s_d[0];
    assign ce_fall   = ~s_q[0] &  s_d[0];
    assign sclk_rise =  s_q[1] & ~s_d[1] & s_q[0];
    assign sclk_fall = ~s_q[1] &  s_d[1] & s_q[0];

    rtc3w_engine u_eng (
        .clk(clk), .rst(rst),
        .ce_rise(ce_rise), .ce_fall(ce_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(s_q[2]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .we(ser_we), .waddr(ser_addr), .wdata(ser_wdata),
        .sdo(sdo), .sdo_oe(sdo_oe), .rd_phase(rd_phase)
    );

    rtc3w_regbank u_bank (
        .clk(clk), .rst(rst),
        .ser_we(ser_we), .ser_addr(ser_addr), .ser_wdata(ser_wdata),
        .tk_we(tk_we), .tk_addr(tk_addr), .tk_wdata(tk_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .tk_rdata(tk_rdata),
        .bank_flat(bank_flat)
    );

    assign halt = bank_flat[FLAG_BIT];
    assign wp   = bank_flat[WP_REG*DW + FLAG_BIT];
endmodule

// File: rtl/rtc3w_checker.sv
module rtc3w_checker
    import rtc3w_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sdo_oe,
    input logic               rd_phase,
    input logic               ce_rise,
    input logic               ce_fall,
    input logic               ser_we,
    input logic [AW-1:0]      ser_addr,
    input logic               wp,
    input logic [NREG*DW-1:0] bank_flat
);
    logic [AW:0] wr_count;

    always_ff @(posedge clk) begin
        if (rst || ce_rise) wr_count <= '0;
        else if (ser_we)    wr_count <= wr_count + 1'b1;
    end

    // R3: the data line is driven only in the read data phase
    assert_oe_in_read_R3: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> rd_phase);

    // R5: a protected write to registers 0..6 leaves the bank untouched
    assert_wp_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (ser_we && wp && ser_addr != AW'(WP_REG)) |=> bank_flat == $past(bank_flat));

    // R8: no frame produces more than one write per register
    assert_burst_cap_R8: assert property (@(posedge clk) disable iff (rst)
        ser_we |-> wr_count < (AW+1)'(NREG));

    // R10: a falling enable releases the data line
    assert_ce_release_R10: assert property (@(posedge clk) disable iff (rst)
        ce_fall |=> !sdo_oe);
endmodule

bind rtc3w_slave rtc3w_checker u_chk (
    .clk(clk), .rst(rst), .sdo_oe(sdo_oe), .rd_phase(rd_phase),
    .ce_rise(ce_rise), .ce_fall(ce_fall), .ser_we(ser_we),
    .ser_addr(ser_addr), .wp(wp), .bank_flat(bank_flat)
);

// File: tb/rtc3w_slave_test.sv
`timescale 1ns/1ps
module rtc3w_slave_test;
    localparam int HALF = 10;
    localparam int NV   = 21;
    // {cmd, write data, expected read, requirement}
    localparam logic [31:0] VEC [NV] = '{
        {8'h8F, 8'h00, 8'h80, 8'd1}, {8'h81, 8'h00, 8'h80, 8'd1},
        {8'h82, 8'h33, 8'h00, 8'd5}, {8'h83, 8'h00, 8'h00, 8'd5},
        {8'h8E, 8'h00, 8'h00, 8'd5}, {8'h82, 8'h33, 8'h00, 8'd4},
        {8'h83, 8'h00, 8'h33, 8'd4}, {8'h8A, 8'hA5, 8'h00, 8'd4},
        {8'h8B, 8'h00, 8'hA5, 8'd3}, {8'h80, 8'h00, 8'h00, 8'd6},
        {8'h81, 8'h00, 8'h00, 8'd6}, {8'h02, 8'hFF, 8'h00, 8'd9},
        {8'hC2, 8'hFF, 8'h00, 8'd9}, {8'h03, 8'h00, 8'h00, 8'd9},
        {8'h83, 8'h00, 8'h33, 8'd9}, {8'h8E, 8'h80, 8'h00, 8'd5},
        {8'h8A, 8'h11, 8'h00, 8'd5}, {8'h8B, 8'h00, 8'hA5, 8'd5},
        {8'h8E, 8'h00, 8'h00, 8'd5}, {8'h8F, 8'h00, 8'h00, 8'd5},
        {8'h9B, 8'h00, 8'hA5, 8'd2}
    };

    logic clk = 0, rst = 1, ce = 0, sclk = 0, sdi = 0;
    logic tk_we = 0;
    logic [2:0] tk_addr = 0;
    logic [7:0] tk_wdata = 0;
    logic sdo, sdo_oe, halt;
    logic [7:0] tk_rdata;
    int checks = 0, fails = 0;
    logic oe_in_cmd;

    always #2.5 clk = ~clk;

    rtc3w_slave uut (
        .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .halt(halt),
        .tk_we(tk_we), .tk_addr(tk_addr), .tk_wdata(tk_wdata), .tk_rdata(tk_rdata)
    );

    function automatic string tag(input logic [7:0] t);
        case (t)
            8'd1: return "R1";  8'd2: return "R2";  8'd3: return "R3";
            8'd4: return "R4";  8'd5: return "R5";  8'd6: return "R6";
            8'd9: return "R9";  default: return "R?";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_half();
        if (sdo_oe) oe_in_cmd = 1'b1;
        sclk = 1;
        wait_half();
        sclk = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic all_oe, output logic any_oe);
        all_oe = 1'b1; any_oe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wait_half();
            b[i] = sdo;
            if (sdo_oe) any_oe = 1'b1; else all_oe = 1'b0;
            sclk = 1;
            wait_half();
            sclk = 0;
        end
    endtask

    task automatic frame_start();
        oe_in_cmd = 1'b0;
        ce = 1;
        wait_half();
    endtask

    task automatic frame_end();
        wait_half();
        ce = 0;
        wait_half();
        wait_half();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        logic all_oe, any_oe;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(halt == 1'b1, "R1 halt", halt, 1);
        check(sdo_oe == 1'b0, "R1 sdo_oe", sdo_oe, 0);
        tk_addr = 3'd0; #1;
        check(tk_rdata == 8'h80, "R1 reg0", tk_rdata, 8'h80);
        tk_addr = 3'd3; #1;
        check(tk_rdata == 8'h00, "R1 reg3", tk_rdata, 8'h00);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] c, d, e, t;
            {c, d, e, t} = VEC[v];
            frame_start();
            send_byte(c);
            if (c[0]) begin
                recv_byte(b, all_oe, any_oe);
                if (c[7] && !c[6]) begin
                    check(b == e, tag(t), b, e);
                    check(all_oe, "R3 oe during data", all_oe, 1);
                end else begin
                    check(!any_oe, "R9 no drive", any_oe, 0);
                end
            end else begin
                send_byte(d);
            end
            check(!oe_in_cmd, "R3 oe low in command/write", oe_in_cmd, 0);
            frame_end();
            check(!sdo_oe, "R3 oe low after frame", sdo_oe, 0);
        end
        // R6: reg0 written to 0x00 above
        check(halt == 1'b0, "R6 halt cleared", halt, 0);

        // R8: burst write of 8 bytes plus an extra one
        frame_start();
        send_byte(8'hBE);
        for (int i = 0; i < 7; i++) send_byte(8'h10 + 8'(i));
        send_byte(8'h00);
        send_byte(8'hEE);
        frame_end();

        // R7: burst read of the whole bank
        frame_start();
        send_byte(8'hBF);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            exp = (i == 7) ? 8'h00 : 8'h10 + 8'(i);
            recv_byte(b, all_oe, any_oe);
            check(b == exp, (i == 0) ? "R8 reg0 not overwritten" : "R7 burst byte", b, exp);
            check(all_oe, "R7 oe during burst", all_oe, 1);
        end
        recv_byte(b, all_oe, any_oe);
        check(!any_oe, "R7 no drive after 64 bits", any_oe, 0);
        frame_end();

        // R10: abort a read mid-byte
        frame_start();
        send_byte(8'h8B);
        for (int i = 0; i < 3; i++) begin
            wait_half(); sclk = 1; wait_half(); sclk = 0;
        end
        check(sdo_oe, "R10 oe before abort", sdo_oe, 1);
        ce = 0;
        repeat (8) @(negedge clk);
        check(!sdo_oe, "R10 oe released", sdo_oe, 0);
        wait_half();

        // R10: partial command then partial write are discarded
        frame_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        frame_end();
        frame_start();
        send_byte(8'h8A);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        frame_end();
        frame_start();
        send_byte(8'h8B);
        recv_byte(b, all_oe, any_oe);
        check(b == 8'h15, "R10 reg5 unchanged", b, 8'h15);
        frame_end();

        // R11: timekeeper writes under protection
        frame_start(); send_byte(8'h8E); send_byte(8'h80); frame_end();
        @(negedge clk);
        tk_addr = 3'd2; tk_wdata = 8'h59; tk_we = 1;
        @(negedge clk);
        tk_we = 0;
        #1;
        check(tk_rdata == 8'h59, "R11 tk readback", tk_rdata, 8'h59);
        tk_addr = 3'd0; #1;
        check(tk_rdata == 8'h10, "R11 tk reg0", tk_rdata, 8'h10);
        frame_start();
        send_byte(8'h85);
        recv_byte(b, all_oe, any_oe);
        check(b == 8'h59, "R11 serial sees tk write", b, 8'h59);
        frame_end();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule